// File: doc/BRIEF.md
# Byte-Order Data Packer

This block is the byte staging store between a 16-bit host data register and a byte-wide two-wire serial sequencer. It holds up to four bytes in one shift store. On the transmit side the host pushes either a 16-bit word or a single byte. The sequencer then pulls bytes back out, most recently written byte last, so the byte that was written first leaves first. On the receive side the sequencer deposits bytes from the low end upward. The host takes them two at a time with a read strobe.

A byte-order control input decides how the two byte lanes of each 16-bit host access map onto the store. The block keeps its own transmit and receive fill counts. It maintains five status flags: transmit-ready, receive-ready, transmit-underflow, receive-overrun and single-byte-read. When a read empties the store while the surrounding controller is in master receive, the block reports that the access is complete.

The three byte streams use valid/ready handshakes. A host write completes when `wr_valid` and `wr_ready` are both high at a rising edge. A drained byte completes when `tx_valid` and `tx_ready` are both high. A received byte completes when `rx_valid` and `rx_ready` are both high. A source that sees its ready low must hold its data until a later edge, and nothing is consumed in the meantime. Only one store operation happens per cycle. A host read (`rd_en`) has first claim. A host write comes second, then a transmit drain, and a receive deposit comes last. Each lower claimant sees its ready or valid forced low while a higher one is active.

Top module: `dpk_top`

## Requirements
- R1: After reset both fill counts are zero and all five flags and `recv_done` are low. `wr_ready` and `rx_ready` are high, and `tx_valid` is low.
- R2: An accepted 16-bit write shifts the store up by two bytes and adds 2 to the transmit count. With `order_be`=1, `wr_data[15:8]` is placed so that it is drained before `wr_data[7:0]`. With `order_be`=0 the two bytes are placed swapped, so `wr_data[7:0]` drains first.
- R3: An accepted 8-bit write (`wr_narrow`=1) shifts the store up by one byte and places `wr_data[7:0]` in the lowest byte. It adds 1 to the transmit count.
- R4: `wr_ready` is low whenever more than two transmit bytes are held, so the transmit count never exceeds four. An offered write that is refused leaves the count unchanged.
- R5: `tx_valid` is high when the transmit count is nonzero, unless a read or write is offered in that cycle. `tx_data` is the held byte at lane count-1. Each drain lowers the count by 1 and sets transmit-ready once two or fewer bytes remain.
- R6: Every accepted write clears transmit-underflow, and clears transmit-ready if more than two bytes are then held. Transmit-underflow is set when `tx_ready` is high while the transmit count is zero and no read or write is offered.
- R7: An accepted receive byte lands in lane rx_count (lane k is bits 8k+7:8k). It raises the receive count by 1 and sets receive-ready. `rx_ready` is low when four bytes are held. A byte offered then is dropped and sets receive-overrun.
- R8: A read returns lanes 0 and 1 of the store. With `order_be`=1, lane 0 appears in `rd_data[15:8]` and lane 1 in `rd_data[7:0]`. With `order_be`=0, lane 1 appears in `rd_data[15:8]` and lane 0 in `rd_data[7:0]`. With more than two bytes held, the store shifts down by two bytes and the count drops by 2.
- R9: A read while exactly one receive byte is held sets single-byte-read and leaves the receive count at zero.
- R10: Every read clears receive-overrun. A read that leaves the receive count at zero clears receive-ready. If `mst_rx` is high in that cycle, `recv_done` pulses high for the following cycle.
- R11: A read with an empty receive store returns zero and leaves the count at zero.
- R12: `rd_en` forces `wr_ready` low. An offered write forces `tx_valid` low. Any read, write or drain in a cycle forces `rx_ready` low.
- R13: Writing 1 to `clr_flags` bit 0, bit 1 or bit 2 clears transmit-underflow, receive-overrun or single-byte-read respectively, unless the flag is being set in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| order_be | input | 1 | Byte-order select for 16-bit host accesses |
| mst_rx | input | 1 | Controller is in master receive |
| wr_valid | input | 1 | Host write offered |
| wr_ready | output | 1 | Host write can be accepted |
| wr_narrow | input | 1 | Write carries one byte instead of two |
| wr_data | input | 16 | Host write data |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 16 | Host read data (valid in the strobe cycle) |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Sequencer takes / requests a transmit byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Received byte can be accepted |
| rx_data | input | 8 | Received byte |
| clr_flags | input | 3 | Clear underflow / overrun / single-byte flags |
| tx_count | output | 3 | Transmit bytes held |
| rx_count | output | 3 | Receive bytes held |
| flag_xrdy | output | 1 | Transmit-ready |
| flag_rrdy | output | 1 | Receive-ready |
| flag_xudf | output | 1 | Transmit-underflow |
| flag_rovr | output | 1 | Receive-overrun |
| flag_sbd | output | 1 | Single-byte-read |
| recv_done | output | 1 | Master receive access complete pulse |

## Verification
The assertions assume the sequencer never drives `tx_ready` and `rx_valid` in the same direction-conflicting way that would make one transfer both send and receive. They also assume `rd_en` is a single-cycle strobe rather than a level held across cycles. The stimulus drives every request for exactly one cycle between falling edges. It never mixes transmit drains with receive deposits in the same phase, so each store operation is isolated. Where priority is exercised, the competing requests are raised deliberately together and the blocked side's handshake signal is observed.

// File: rtl/dpk_pkg.sv
package dpk_pkg;
  typedef enum int unsigned {
    FL_XRDY = 0,
    FL_RRDY = 1,
    FL_XUDF = 2,
    FL_ROVR = 3,
    FL_SBD  = 4
  } flag_e;
  localparam int NFLAG = 5;
  localparam int LANE  = 8;
endpackage

// File: rtl/dpk_lane_swap.sv
module dpk_lane_swap #(
  parameter int LANE = 8
) (
  input  logic [2*LANE-1:0] din,
  input  logic              swap,
  output logic [2*LANE-1:0] dout
);
  always_comb begin
    if (swap) dout = {din[LANE-1:0], din[2*LANE-1:LANE]};
    else      dout = din;
  end
endmodule

// File: rtl/dpk_flags.sv
module dpk_flags #(
  parameter int NF = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set,
  input  logic [NF-1:0] clr,
  output logic [NF-1:0] q
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end

    // R13
    flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]);
  end
endmodule

// File: rtl/dpk_top.sv
module dpk_top #(
  parameter int BYTES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        order_be,
  input  logic        mst_rx,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic        wr_narrow,
  input  logic [15:0] wr_data,
  input  logic        rd_en,
  output logic [15:0] rd_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  input  logic [2:0]  clr_flags,
  output logic [$clog2(BYTES+1)-1:0] tx_count,
  output logic [$clog2(BYTES+1)-1:0] rx_count,
  output logic        flag_xrdy,
  output logic        flag_rrdy,
  output logic        flag_xudf,
  output logic        flag_rovr,
  output logic        flag_sbd,
  output logic        recv_done
);
  import dpk_pkg::*;

  localparam int BUFW = LANE * BYTES;
  localparam int CW   = $clog2(BYTES + 1);
  localparam logic [CW-1:0] FULL  = CW'(BYTES);
  localparam logic [CW-1:0] LIMIT = CW'(BYTES - 2);
  localparam logic [CW-1:0] ONE   = CW'(1);
  localparam logic [CW-1:0] TWO   = CW'(2);

  logic [BUFW-1:0] hold_q, hold_d;
  logic [CW-1:0]   txc_q, txc_d, rxc_q, rxc_d;
  logic [15:0]     wr_lane, rd_lane;
  logic            wr_fire, tx_fire, rx_fire, rd_empties, done_q;
  logic [NFLAG-1:0] fset, fclr, fq;

  // handshakes and priority: read > write > drain > receive
  assign wr_ready = (txc_q <= LIMIT) && !rd_en;
  assign wr_fire  = wr_valid && wr_ready;
  assign tx_valid = (txc_q != '0) && !wr_valid && !rd_en;
  assign tx_fire  = tx_valid && tx_ready;
  assign rx_ready = (rxc_q < FULL) && !rd_en && !wr_fire && !tx_fire;
  assign rx_fire  = rx_valid && rx_ready;
  assign rd_empties = rd_en && (rxc_q <= TWO);

  dpk_lane_swap #(.LANE(LANE)) u_wr_swap (
    .din (wr_data),
    .swap(!order_be),
    .dout(wr_lane)
  );

  dpk_lane_swap #(.LANE(LANE)) u_rd_swap (
    .din (hold_q[15:0]),
    .swap(order_be),
    .dout(rd_lane)
  );

  assign rd_data = (rxc_q == '0) ? 16'h0000 : rd_lane;

  always_comb begin
    tx_data = '0;
    for (int i = 0; i < BYTES; i++)
      if (txc_q == CW'(i + 1)) tx_data = hold_q[LANE*i +: LANE];
  end

  // store and counters
  always_comb begin
    hold_d = hold_q;
    txc_d  = txc_q;
    rxc_d  = rxc_q;
    if (rd_en) begin
      if (rxc_q > TWO) begin
        hold_d = {16'h0000, hold_q[BUFW-1:16]};
        rxc_d  = rxc_q - TWO;
      end else begin
        if (rxc_q != '0) hold_d = '0;
        rxc_d = '0;
      end
    end else if (wr_fire) begin
      if (wr_narrow) begin
        hold_d = {hold_q[BUFW-LANE-1:0], wr_data[7:0]};
        txc_d  = txc_q + ONE;
      end else begin
        hold_d = {hold_q[BUFW-17:0], wr_lane};
        txc_d  = txc_q + TWO;
      end
    end else if (tx_fire) begin
      txc_d = txc_q - ONE;
    end else if (rx_fire) begin
      for (int i = 0; i < BYTES; i++)
        if (rxc_q == CW'(i)) hold_d[LANE*i +: LANE] = rx_data;
      rxc_d = rxc_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      txc_q  <= '0;
      rxc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      txc_q  <= txc_d;
      rxc_q  <= rxc_d;
      done_q <= rd_empties && mst_rx;
    end
  end

  // flag events
  always_comb begin
    fset = '0;
    fclr = '0;
    fset[FL_XRDY] = tx_fire && (txc_q <= LIMIT + ONE);
    fclr[FL_XRDY] = wr_fire && (txc_d > LIMIT);
    fset[FL_RRDY] = rx_fire;
    fclr[FL_RRDY] = rd_empties;
    fset[FL_XUDF] = tx_ready && (txc_q == '0) && !wr_valid && !rd_en;
    fclr[FL_XUDF] = wr_fire || clr_flags[0];
    fset[FL_ROVR] = rx_valid && (rxc_q == FULL) && !rd_en;
    fclr[FL_ROVR] = rd_en || clr_flags[1];
    fset[FL_SBD]  = rd_en && (rxc_q == ONE);
    fclr[FL_SBD]  = clr_flags[2];
  end

  dpk_flags #(.NF(NFLAG)) u_flags (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (fset),
    .clr  (fclr),
    .q    (fq)
  );

  assign flag_xrdy = fq[FL_XRDY];
  assign flag_rrdy = fq[FL_RRDY];
  assign flag_xudf = fq[FL_XUDF];
  assign flag_rovr = fq[FL_ROVR];
  assign flag_sbd  = fq[FL_SBD];
  assign recv_done = done_q;
  assign tx_count  = txc_q;
  assign rx_count  = rxc_q;

  // R4
  tx_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= FULL);

  // R7
  rx_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= FULL);

  // R5
  drain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (tx_count == $past(tx_count) - ONE));

  // R6
  wr_clears_udf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !flag_xudf);

  // R10
  rd_clears_rovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !flag_rovr);

  // R10
  rd_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rx_count <= TWO) |=> (rx_count == '0 && !flag_rrdy));

  // R12
  rd_blocks_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (!wr_ready && !tx_valid && !rx_ready));
endmodule

// File: tb/dpk_top_bench.sv
module dpk_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;
  // {op[2:0], be, data[15:0], expect[15:0]}
  // op 0 wide write, 1 byte write, 2 read, 3 drain, 4 receive
  localparam logic [35:0] VEC [NVEC] = '{
    {3'd0, 1'b1, 16'hA1B2, 16'h0002},
    {3'd1, 1'b1, 16'h00C3, 16'h0003},
    {3'd3, 1'b1, 16'h0000, 16'h00A1},
    {3'd3, 1'b1, 16'h0000, 16'h00B2},
    {3'd3, 1'b1, 16'h0000, 16'h00C3},
    {3'd0, 1'b0, 16'h1122, 16'h0002},
    {3'd3, 1'b0, 16'h0000, 16'h0022},
    {3'd3, 1'b0, 16'h0000, 16'h0011},
    {3'd4, 1'b1, 16'h005A, 16'h0001},
    {3'd4, 1'b1, 16'h006B, 16'h0002},
    {3'd4, 1'b1, 16'h007C, 16'h0003},
    {3'd4, 1'b1, 16'h008D, 16'h0004},
    {3'd2, 1'b1, 16'h0000, 16'h5A6B},
    {3'd2, 1'b0, 16'h0000, 16'h8D7C},
    {3'd2, 1'b1, 16'h0000, 16'h0000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic order_be = 1'b1, mst_rx = 1'b0;
  logic wr_valid = 1'b0, wr_narrow = 1'b0, rd_en = 1'b0;
  logic tx_ready = 1'b0, rx_valid = 1'b0;
  logic [15:0] wr_data = '0;
  logic [7:0]  rx_data = '0;
  logic [2:0]  clr_flags = '0;
  logic wr_ready, tx_valid, rx_ready;
  logic [15:0] rd_data;
  logic [7:0]  tx_data;
  logic [2:0]  tx_count, rx_count;
  logic flag_xrdy, flag_rrdy, flag_xudf, flag_rovr, flag_sbd, recv_done;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpk_top u_dpk_top (
    .clk(clk), .rst_n(rst_n), .order_be(order_be), .mst_rx(mst_rx),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_narrow(wr_narrow),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .clr_flags(clr_flags), .tx_count(tx_count), .rx_count(rx_count),
    .flag_xrdy(flag_xrdy), .flag_rrdy(flag_rrdy), .flag_xudf(flag_xudf),
    .flag_rovr(flag_rovr), .flag_sbd(flag_sbd), .recv_done(recv_done)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_valid = 1'b0; wr_narrow = 1'b0; rd_en = 1'b0;
    tx_ready = 1'b0; rx_valid = 1'b0; clr_flags = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // one-cycle operations starting and ending at a falling edge
  task automatic wr_op(input bit narrow, input logic [15:0] d);
    wr_valid = 1'b1; wr_narrow = narrow; wr_data = d;
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic drain_op(output logic [7:0] b);
    tx_ready = 1'b1; #1 b = tx_data;
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic rx_op(input logic [7:0] d);
    rx_valid = 1'b1; rx_data = d;
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic rd_op(output logic [15:0] d);
    rd_en = 1'b1; #1 d = rd_data;
    @(posedge clk); @(negedge clk); idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 1'b1, 1'b0);
    finish_run();
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 tx_count", 16'(tx_count), 16'h0);
    chk("R1 rx_count", 16'(rx_count), 16'h0);
    chk("R1 flags", {10'h0, flag_xrdy, flag_rrdy, flag_xudf, flag_rovr, flag_sbd, recv_done}, 16'h0);
    chk("R1 handshakes", {13'h0, wr_ready, rx_ready, tx_valid}, 16'h0006);

    // table walk: R2 wide writes, R3 byte writes, R5 drains, R7 receives, R8 reads
    for (int i = 0; i < NVEC; i++) begin
      logic [2:0] op;
      logic [15:0] cap, act;
      op = VEC[i][35:33];
      @(negedge clk);
      order_be = VEC[i][32];
      case (op)
        3'd0: begin wr_valid = 1'b1; wr_narrow = 1'b0; wr_data = VEC[i][31:16]; end
        3'd1: begin wr_valid = 1'b1; wr_narrow = 1'b1; wr_data = VEC[i][31:16]; end
        3'd2: rd_en = 1'b1;
        3'd3: tx_ready = 1'b1;
        default: begin rx_valid = 1'b1; rx_data = VEC[i][23:16]; end
      endcase
      #1 cap = (op == 3'd2) ? rd_data : (op == 3'd3) ? {8'h00, tx_data} : 16'h0;
      @(posedge clk); @(negedge clk); idle();
      case (op)
        3'd0, 3'd1: act = 16'(tx_count);
        3'd4: act = 16'(rx_count);
        default: act = cap;
      endcase
      case (op)
        3'd0: chk("R2 wide write", act, VEC[i][15:0]);
        3'd1: chk("R3 byte write", act, VEC[i][15:0]);
        3'd2: chk("R8 read lanes", act, VEC[i][15:0]);
        3'd3: chk("R5 drain order", act, VEC[i][15:0]);
        default: chk("R7 receive count", act, VEC[i][15:0]);
      endcase
    end

    // R4 / R6: filling past two bytes
    order_be = 1'b1;
    wr_op(1'b0, 16'h0102);
    chk("R6 xrdy kept at 2", 16'(flag_xrdy), 16'h1);
    wr_op(1'b0, 16'h0304);
    chk("R6 xrdy cleared above 2", 16'(flag_xrdy), 16'h0);
    chk("R4 wr_ready low when full", 16'(wr_ready), 16'h0);
    wr_op(1'b0, 16'hFFFF);
    chk("R4 refused write count", 16'(tx_count), 16'h4);
    drain_op(b); drain_op(b);
    chk("R5 xrdy set at 2 left", 16'(flag_xrdy), 16'h1);
    drain_op(b); drain_op(b);
    chk("R5 last byte", 16'(b), 16'h0004);
    // underflow set then cleared by a write
    tx_ready = 1'b1; @(posedge clk); @(negedge clk); idle();
    chk("R6 underflow set", 16'(flag_xudf), 16'h1);
    wr_op(1'b1, 16'h0055);
    chk("R6 underflow cleared", 16'(flag_xudf), 16'h0);
    // R12 write beats drain
    wr_valid = 1'b1; wr_narrow = 1'b1; wr_data = 16'h0066; tx_ready = 1'b1;
    #1 chk("R12 tx_valid blocked by write", 16'(tx_valid), 16'h0);
    @(posedge clk); @(negedge clk); idle();
    chk("R12 write taken, no drain", 16'(tx_count), 16'h2);
    drain_op(b);
    chk("R5 first of two bytes", 16'(b), 16'h0055);
    drain_op(b);
    chk("R5 second of two bytes", 16'(b), 16'h0066);

    // R7 overrun
    rx_op(8'h01);
    chk("R7 rrdy set", 16'(flag_rrdy), 16'h1);
    rx_op(8'h02); rx_op(8'h03); rx_op(8'h04);
    rx_valid = 1'b1; rx_data = 8'hEE;
    #1 chk("R7 rx_ready low when full", 16'(rx_ready), 16'h0);
    @(posedge clk); @(negedge clk); idle();
    chk("R7 overrun set", 16'(flag_rovr), 16'h1);
    chk("R7 full byte dropped", 16'(rx_count), 16'h4);
    // R12 read beats write; R10 read clears overrun
    rd_en = 1'b1; wr_valid = 1'b1; wr_narrow = 1'b1; wr_data = 16'h0077;
    #1 chk("R12 wr_ready blocked by read", 16'(wr_ready), 16'h0);
    w = rd_data;
    @(posedge clk); @(negedge clk); idle();
    chk("R8 read first pair", w, 16'h0102);
    chk("R10 overrun cleared", 16'(flag_rovr), 16'h0);
    chk("R12 blocked write not taken", 16'(tx_count), 16'h0);
    mst_rx = 1'b1;
    rd_op(w);
    chk("R8 read second pair", w, 16'h0304);
    chk("R10 rrdy cleared", 16'(flag_rrdy), 16'h0);
    chk("R10 done pulse", 16'(recv_done), 16'h1);
    mst_rx = 1'b0;
    @(negedge clk);
    chk("R10 done pulse ends", 16'(recv_done), 16'h0);

    // R9 single byte, R13 clear, R11 empty read
    rx_op(8'h9A);
    rd_op(w);
    chk("R8 single byte lanes", w, 16'h9A00);
    chk("R9 sbd set", 16'(flag_sbd), 16'h1);
    chk("R9 count emptied", 16'(rx_count), 16'h0);
    clr_flags = 3'b100; @(posedge clk); @(negedge clk); idle();
    chk("R13 sbd cleared", 16'(flag_sbd), 16'h0);
    rd_op(w);
    chk("R11 empty read data", w, 16'h0000);
    chk("R11 empty read count", 16'(rx_count), 16'h0);
    finish_run();
  end
endmodule